// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Through Cache Controller

This block sits between a processor request port and a slower backing memory. Each processor address is split into a set index and a tag. Each set is one packed storage word that holds two tag/data pairs, and each pair has its own valid bit. A request reads the indexed word in one cycle. In the next cycle both stored tags are compared with the request tag at the same time. A read hit is answered straight from the cache. A read miss fetches the word from backing memory over a request/acknowledge read port and installs it in the way chosen for replacement.

A way that is still invalid is filled first. When both ways are valid, a one-bit least-recently-used marker per set picks the victim. Every hit and every fill sets that marker to the other way. Writes are write-through: each write goes out on a separate write port. A write that hits also updates the cached copy. A write that misses does not allocate a line. The processor side uses a valid/ready handshake. Ready is high only while the controller is idle.

Top module: `sa2_cache_ctrl`

## Requirements
- R1: After reset every way of every set is invalid, so the first read of any address is a miss that issues a backing-memory read. Ready is high and no response, read request or write request is pending.
- R2: Address bits [8:0] select the set and bits [14:9] form the tag. Addresses that differ only in the tag share a set. Addresses with the same tag but a different index do not interfere with each other.
- R3: A read hit raises the one-cycle response strobe two cycles after the accepting edge and returns the cached word. It issues no backing-memory read.
- R4: A read miss raises the memory read request with the full request address. The request and its address are held until acknowledged. The word presented with the acknowledge is returned in the cycle after it. Ready stays low from acceptance until the response.
- R5: A miss into a set that still has an invalid way fills that invalid way. Both entries then hit.
- R6: A miss into a set whose two ways are both valid replaces the least recently used way. The other way survives.
- R7: Every hit, whether a read or a write, and every fill marks the other way as the next victim.
- R8: Every accepted write produces exactly one write-port pulse carrying the request address and data. The pulse falls in the same cycle as the write's response.
- R9: A write that hits updates the cached word. A later read of that address hits and returns the new data.
- R10: A write that misses issues no memory read and installs nothing. A later read of that address misses, and the entries already in that set are not disturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Controller can accept a request |
| cpu_req_we | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | 15 | Word address: tag [14:9], index [8:0] |
| cpu_req_wdata | input | 12 | Write data |
| cpu_rsp_valid | output | 1 | One-cycle completion strobe |
| cpu_rsp_rdata | output | 12 | Read data, valid with the strobe on reads |
| mem_rd_valid | output | 1 | Backing-memory read request, held until acknowledged |
| mem_rd_addr | output | 15 | Backing-memory read address |
| mem_rd_ack | input | 1 | Read acknowledge, one cycle, carries the data |
| mem_rd_data | input | 12 | Read data returned with the acknowledge |
| mem_wr_valid | output | 1 | One-cycle write-through pulse |
| mem_wr_addr | output | 15 | Write-through address |
| mem_wr_data | output | 12 | Write-through data |

## Verification
The main lookup is driven with several access patterns. A repeated read of one address separates a hit from a miss by read traffic and latency. Pairs of addresses that share an index but differ in tag show that both ways are used. Addresses that share a tag but differ in index show that sets do not alias. Three-tag sequences within one set, with the hits placed in different orders, show whether the victim follows recency or a fixed way. Write hits and write misses that are followed by reads of the same set show whether a write updates the stored data and the replacement marker, or installs nothing at all.

// File: rtl/sa2_cache_pkg.sv
// Package: shared constants and the controller state type.
// Assumes a fixed associativity of two, with one recency bit per set.
package sa2_cache_pkg;
    localparam int NUM_WAYS = 2;
    localparam int WAY_W    = 1;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOOKUP = 2'd1,
        ST_FILL   = 2'd2
    } ctl_state_e;
endpackage

// File: rtl/sa2_set_store.sv
// Set store: one packed word per set holding NUM_WAYS tag/data pairs.
// Per-way valid bits and a per-set recency bit are kept in flops that reset.
// Reads are registered (one-cycle latency). A write replaces one pair and sets its valid bit.
// Assumes the caller never reads and writes the same set in the same cycle.
module sa2_set_store
    import sa2_cache_pkg::*;
#(
    parameter int IDX_W  = 9,
    parameter int TAG_W  = 6,
    parameter int DATA_W = 12
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               rd_en,
    input  logic [IDX_W-1:0]                   rd_idx,
    output logic [NUM_WAYS-1:0][TAG_W-1:0]     rd_tag,
    output logic [NUM_WAYS-1:0][DATA_W-1:0]    rd_data,
    output logic [NUM_WAYS-1:0]                rd_vld,
    output logic                               rd_lru,
    input  logic                               wr_en,
    input  logic [IDX_W-1:0]                   wr_idx,
    input  logic [WAY_W-1:0]                   wr_way,
    input  logic [TAG_W-1:0]                   wr_tag,
    input  logic [DATA_W-1:0]                  wr_data,
    input  logic                               lru_en,
    input  logic [IDX_W-1:0]                   lru_idx,
    input  logic                               lru_val
);
    localparam int PAIR_W = TAG_W + DATA_W;
    localparam int WORD_W = NUM_WAYS * PAIR_W;
    localparam int SETS   = 1 << IDX_W;

    logic [WORD_W-1:0]                words [SETS];
    logic [SETS-1:0][NUM_WAYS-1:0]    vld_q;
    logic [SETS-1:0]                  lru_q;
    logic [WORD_W-1:0]                rd_word_q;

    // Pair write into the packed storage word (no reset, gated by valid bits).
    always_ff @(posedge clk) begin
        if (wr_en)
            words[wr_idx][int'(wr_way)*PAIR_W +: PAIR_W] <= {wr_tag, wr_data};
    end

    // Valid and recency bookkeeping, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            lru_q <= '0;
        end else begin
            if (wr_en)
                vld_q[wr_idx][wr_way] <= 1'b1;
            if (lru_en)
                lru_q[lru_idx] <= lru_val;
        end
    end

    // Registered read of the word, its valid bits and its recency bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_word_q <= '0;
            rd_vld    <= '0;
            rd_lru    <= 1'b0;
        end else if (rd_en) begin
            rd_word_q <= words[rd_idx];
            rd_vld    <= vld_q[rd_idx];
            rd_lru    <= lru_q[rd_idx];
        end
    end

    // Unpack the read word into per-way tag and data fields.
    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_unpack
        assign rd_tag[w]  = rd_word_q[w*PAIR_W + DATA_W +: TAG_W];
        assign rd_data[w] = rd_word_q[w*PAIR_W +: DATA_W];
    end
endmodule

// File: rtl/sa2_tag_match.sv
// Tag match: compares the request tag with every valid stored tag in parallel.
// Returns the hit flag, the matching way and its data.
// Assumes at most one way matches, which the fill policy guarantees.
module sa2_tag_match
    import sa2_cache_pkg::*;
#(
    parameter int TAG_W  = 6,
    parameter int DATA_W = 12
) (
    input  logic [NUM_WAYS-1:0][TAG_W-1:0]  way_tag,
    input  logic [NUM_WAYS-1:0][DATA_W-1:0] way_data,
    input  logic [NUM_WAYS-1:0]             way_vld,
    input  logic [TAG_W-1:0]                req_tag,
    output logic                            hit,
    output logic [WAY_W-1:0]                hit_way,
    output logic [DATA_W-1:0]               hit_data
);
    logic [NUM_WAYS-1:0] hit_vec;

    // One comparator per way.
    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_cmp
        assign hit_vec[w] = way_vld[w] && (way_tag[w] == req_tag);
    end

    // Reduce the per-way results into the way number and the selected data.
    always_comb begin
        hit      = |hit_vec;
        hit_way  = '0;
        hit_data = '0;
        for (int w = 0; w < NUM_WAYS; w++) begin
            if (hit_vec[w]) begin
                hit_way  = WAY_W'(w);
                hit_data = hit_data | way_data[w];
            end
        end
    end
endmodule

// File: rtl/sa2_victim_sel.sv
// Victim select: picks the lowest-numbered invalid way if there is one.
// Otherwise it picks the way named by the set's recency bit.
module sa2_victim_sel
    import sa2_cache_pkg::*;
(
    input  logic [NUM_WAYS-1:0] way_vld,
    input  logic                lru_way,
    output logic [WAY_W-1:0]    victim
);
    // Invalid ways take precedence over recency.
    always_comb begin
        victim = WAY_W'(lru_way);
        for (int w = NUM_WAYS - 1; w >= 0; w--) begin
            if (!way_vld[w])
                victim = WAY_W'(w);
        end
    end
endmodule

// File: rtl/sa2_cache_ctrl.sv
// Two-way set-associative write-through cache controller (top).
// Flow: IDLE accepts a request and reads the set. LOOKUP compares tags and
// finishes hits and writes. FILL waits for the backing-memory word on a read miss.
// Assumes the backing memory acknowledges each held read request once, and that
// the write port always accepts.
module sa2_cache_ctrl
    import sa2_cache_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int IDX_W  = 9,
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req_valid,
    output logic              cpu_req_ready,
    input  logic              cpu_req_we,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    input  logic [DATA_W-1:0] cpu_req_wdata,
    output logic              cpu_rsp_valid,
    output logic [DATA_W-1:0] cpu_rsp_rdata,
    output logic              mem_rd_valid,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rd_ack,
    input  logic [DATA_W-1:0] mem_rd_data,
    output logic              mem_wr_valid,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [DATA_W-1:0] mem_wr_data
);
    localparam int TAG_W = ADDR_W - IDX_W;

    ctl_state_e                       state_q;
    logic                             req_we_q;
    logic [ADDR_W-1:0]                req_addr_q;
    logic [DATA_W-1:0]                req_wdata_q;
    logic [WAY_W-1:0]                 victim_q;

    logic                             accept;
    logic [IDX_W-1:0]                 idx_q;
    logic [TAG_W-1:0]                 tag_q;

    logic [NUM_WAYS-1:0][TAG_W-1:0]   st_tag;
    logic [NUM_WAYS-1:0][DATA_W-1:0]  st_data;
    logic [NUM_WAYS-1:0]              st_vld;
    logic                             st_lru;

    logic                             hit;
    logic [WAY_W-1:0]                 hit_way;
    logic [DATA_W-1:0]                hit_data;
    logic [WAY_W-1:0]                 victim;

    logic                             wr_en;
    logic [WAY_W-1:0]                 wr_way;
    logic [DATA_W-1:0]                wr_data;
    logic                             lru_en;
    logic                             lru_val;

    // Handshake: accept only while idle and out of reset.
    assign cpu_req_ready = rst_n && (state_q == ST_IDLE);
    assign accept        = cpu_req_valid && cpu_req_ready;
    assign idx_q         = req_addr_q[IDX_W-1:0];
    assign tag_q         = req_addr_q[ADDR_W-1:IDX_W];

    sa2_set_store #(
        .IDX_W (IDX_W),
        .TAG_W (TAG_W),
        .DATA_W(DATA_W)
    ) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_en  (accept),
        .rd_idx (cpu_req_addr[IDX_W-1:0]),
        .rd_tag (st_tag),
        .rd_data(st_data),
        .rd_vld (st_vld),
        .rd_lru (st_lru),
        .wr_en  (wr_en),
        .wr_idx (idx_q),
        .wr_way (wr_way),
        .wr_tag (tag_q),
        .wr_data(wr_data),
        .lru_en (lru_en),
        .lru_idx(idx_q),
        .lru_val(lru_val)
    );

    sa2_tag_match #(
        .TAG_W (TAG_W),
        .DATA_W(DATA_W)
    ) u_match (
        .way_tag (st_tag),
        .way_data(st_data),
        .way_vld (st_vld),
        .req_tag (tag_q),
        .hit     (hit),
        .hit_way (hit_way),
        .hit_data(hit_data)
    );

    sa2_victim_sel u_victim (
        .way_vld(st_vld),
        .lru_way(st_lru),
        .victim (victim)
    );

    // Store updates: a write hit refreshes the data, an acknowledged fill installs
    // a pair, and either one points the recency bit at the other way.
    always_comb begin
        wr_en   = 1'b0;
        wr_way  = hit_way;
        wr_data = req_wdata_q;
        lru_en  = 1'b0;
        lru_val = 1'b0;
        if (state_q == ST_LOOKUP && hit) begin
            lru_en  = 1'b1;
            lru_val = ~hit_way[0];
            wr_en   = req_we_q;
        end else if (state_q == ST_FILL && mem_rd_ack) begin
            wr_en   = 1'b1;
            wr_way  = victim_q;
            wr_data = mem_rd_data;
            lru_en  = 1'b1;
            lru_val = ~victim_q[0];
        end
    end

    // Capture the request on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_we_q    <= 1'b0;
            req_addr_q  <= '0;
            req_wdata_q <= '0;
        end else if (accept) begin
            req_we_q    <= cpu_req_we;
            req_addr_q  <= cpu_req_addr;
            req_wdata_q <= cpu_req_wdata;
        end
    end

    // Sequencing, response, miss request and write-through outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q       <= ST_IDLE;
            victim_q      <= '0;
            cpu_rsp_valid <= 1'b0;
            cpu_rsp_rdata <= '0;
            mem_rd_valid  <= 1'b0;
            mem_rd_addr   <= '0;
            mem_wr_valid  <= 1'b0;
            mem_wr_addr   <= '0;
            mem_wr_data   <= '0;
        end else begin
            cpu_rsp_valid <= 1'b0;
            mem_wr_valid  <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (accept)
                        state_q <= ST_LOOKUP;
                end
                ST_LOOKUP: begin
                    if (req_we_q) begin
                        mem_wr_valid  <= 1'b1;
                        mem_wr_addr   <= req_addr_q;
                        mem_wr_data   <= req_wdata_q;
                        cpu_rsp_valid <= 1'b1;
                        state_q       <= ST_IDLE;
                    end else if (hit) begin
                        cpu_rsp_valid <= 1'b1;
                        cpu_rsp_rdata <= hit_data;
                        state_q       <= ST_IDLE;
                    end else begin
                        victim_q     <= victim;
                        mem_rd_valid <= 1'b1;
                        mem_rd_addr  <= req_addr_q;
                        state_q      <= ST_FILL;
                    end
                end
                ST_FILL: begin
                    if (mem_rd_ack) begin
                        mem_rd_valid  <= 1'b0;
                        cpu_rsp_valid <= 1'b1;
                        cpu_rsp_rdata <= mem_rd_data;
                        state_q       <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sa2_cache_chk.sv
// Checker for sa2_cache_ctrl. It observes only the top-level ports and is bound to every instance.
module sa2_cache_chk #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req_valid,
    input logic              cpu_req_ready,
    input logic              cpu_req_we,
    input logic [ADDR_W-1:0] cpu_req_addr,
    input logic [DATA_W-1:0] cpu_req_wdata,
    input logic              cpu_rsp_valid,
    input logic [DATA_W-1:0] cpu_rsp_rdata,
    input logic              mem_rd_valid,
    input logic [ADDR_W-1:0] mem_rd_addr,
    input logic              mem_rd_ack,
    input logic [DATA_W-1:0] mem_rd_data,
    input logic              mem_wr_valid,
    input logic [ADDR_W-1:0] mem_wr_addr,
    input logic [DATA_W-1:0] mem_wr_data
);
    logic acc_wr, acc_rd;
    assign acc_wr = cpu_req_valid && cpu_req_ready && cpu_req_we;
    assign acc_rd = cpu_req_valid && cpu_req_ready && !cpu_req_we;

    assert_busy_not_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid |-> !cpu_req_ready);

    assert_fill_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && !mem_rd_ack) |=> (mem_rd_valid && $stable(mem_rd_addr)));

    assert_fill_returns_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && mem_rd_ack) |=> (cpu_rsp_valid && cpu_rsp_rdata == $past(mem_rd_data)));

    assert_miss_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_rd |=> ##1 (!mem_rd_valid || mem_rd_addr == $past(cpu_req_addr, 2)));

    assert_write_through_R8: assert property (@(posedge clk) disable iff (!rst_n)
        acc_wr |=> ##1 (mem_wr_valid && cpu_rsp_valid
                        && mem_wr_addr == $past(cpu_req_addr, 2)
                        && mem_wr_data == $past(cpu_req_wdata, 2)));

    assert_write_no_fill_R10: assert property (@(posedge clk) disable iff (!rst_n)
        acc_wr |=> ##1 !mem_rd_valid);

    assert_rsp_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rsp_valid |=> !cpu_rsp_valid);

    assert_wr_pulse_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_valid |=> !mem_wr_valid);
endmodule

bind sa2_cache_ctrl sa2_cache_chk #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_req_valid(cpu_req_valid),
    .cpu_req_ready(cpu_req_ready),
    .cpu_req_we   (cpu_req_we),
    .cpu_req_addr (cpu_req_addr),
    .cpu_req_wdata(cpu_req_wdata),
    .cpu_rsp_valid(cpu_rsp_valid),
    .cpu_rsp_rdata(cpu_rsp_rdata),
    .mem_rd_valid (mem_rd_valid),
    .mem_rd_addr  (mem_rd_addr),
    .mem_rd_ack   (mem_rd_ack),
    .mem_rd_data  (mem_rd_data),
    .mem_wr_valid (mem_wr_valid),
    .mem_wr_addr  (mem_wr_addr),
    .mem_wr_data  (mem_wr_data)
);

// File: tb/sim_sa2_cache_ctrl.sv
// Directed bench for sa2_cache_ctrl. The backing memory is modelled with a fixed
// read latency: its contents are computed from the address, with a table of overrides
// for words that have been written.
module sim_sa2_cache_ctrl;
    localparam int ADDR_W = 15;
    localparam int IDX_W  = 9;
    localparam int DATA_W = 12;
    localparam int RD_LAT = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cpu_req_valid = 1'b0;
    logic              cpu_req_ready;
    logic              cpu_req_we = 1'b0;
    logic [ADDR_W-1:0] cpu_req_addr = '0;
    logic [DATA_W-1:0] cpu_req_wdata = '0;
    logic              cpu_rsp_valid;
    logic [DATA_W-1:0] cpu_rsp_rdata;
    logic              mem_rd_valid;
    logic [ADDR_W-1:0] mem_rd_addr;
    logic              mem_rd_ack = 1'b0;
    logic [DATA_W-1:0] mem_rd_data = '0;
    logic              mem_wr_valid;
    logic [ADDR_W-1:0] mem_wr_addr;
    logic [DATA_W-1:0] mem_wr_data;

    always #4 clk = ~clk;

    sa2_cache_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u0 (
        .clk(clk), .rst_n(rst_n),
        .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
        .cpu_req_we(cpu_req_we), .cpu_req_addr(cpu_req_addr),
        .cpu_req_wdata(cpu_req_wdata), .cpu_rsp_valid(cpu_rsp_valid),
        .cpu_rsp_rdata(cpu_rsp_rdata), .mem_rd_valid(mem_rd_valid),
        .mem_rd_addr(mem_rd_addr), .mem_rd_ack(mem_rd_ack),
        .mem_rd_data(mem_rd_data), .mem_wr_valid(mem_wr_valid),
        .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data)
    );

    int n_chk = 0;
    int n_bad = 0;
    int fills = 0;
    int rd_cnt = 0;
    logic [ADDR_W-1:0] last_rd_addr = '0;
    logic [DATA_W-1:0] wmem [int];

    function automatic logic [DATA_W-1:0] mfun(input logic [ADDR_W-1:0] a);
        return DATA_W'(a * 7 + 12'h5A3) ^ DATA_W'(a >> 3);
    endfunction

    function automatic logic [DATA_W-1:0] exp_rd(input logic [ADDR_W-1:0] a);
        if (wmem.exists(int'(a))) return wmem[int'(a)];
        return mfun(a);
    endfunction

    function automatic logic [ADDR_W-1:0] mk(input int tag, input int idx);
        return {6'(tag), IDX_W'(idx)};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Backing-memory model: fixed-latency read acknowledge; records written words.
    initial begin
        forever begin
            @(negedge clk);
            if (mem_rd_valid && !mem_rd_ack) begin
                rd_cnt++;
                if (rd_cnt == RD_LAT) begin
                    mem_rd_ack   = 1'b1;
                    mem_rd_data  = exp_rd(mem_rd_addr);
                    last_rd_addr = mem_rd_addr;
                    fills++;
                    rd_cnt = 0;
                end
            end else begin
                mem_rd_ack = 1'b0;
            end
            if (mem_wr_valid)
                wmem[int'(mem_wr_addr)] = mem_wr_data;
        end
    end

    // Drive one request and wait for its response.
    task automatic access(input bit we, input logic [ADDR_W-1:0] addr,
                          input logic [DATA_W-1:0] wd, output logic [DATA_W-1:0] rd,
                          output int lat, output bit filled, output bit rdy_seen,
                          output bit wr_seen, output logic [ADDR_W-1:0] wa,
                          output logic [DATA_W-1:0] wdo);
        int f0;
        @(negedge clk);
        cpu_req_valid = 1'b1;
        cpu_req_we    = we;
        cpu_req_addr  = addr;
        cpu_req_wdata = wd;
        @(posedge clk);
        f0 = fills;
        @(negedge clk);
        cpu_req_valid = 1'b0;
        lat = 1;
        rdy_seen = 1'b0;
        while (!cpu_rsp_valid && lat < 60) begin
            if (cpu_req_ready) rdy_seen = 1'b1;
            @(negedge clk);
            lat++;
        end
        rd      = cpu_rsp_rdata;
        wr_seen = mem_wr_valid;
        wa      = mem_wr_addr;
        wdo     = mem_wr_data;
        filled  = (fills != f0);
    endtask

    task automatic rd_chk(input logic [ADDR_W-1:0] a, input bit exp_hit, input string req);
        logic [DATA_W-1:0] rd, wdo;
        logic [ADDR_W-1:0] wa;
        int lat;
        bit filled, rdy, ws;
        access(1'b0, a, '0, rd, lat, filled, rdy, ws, wa, wdo);
        check(filled == !exp_hit, {req, " hit/miss"}, int'(filled), int'(!exp_hit));
        check(rd == exp_rd(a), {req, " data"}, int'(rd), int'(exp_rd(a)));
        check(lat == (exp_hit ? 2 : RD_LAT + 2), exp_hit ? "R3 latency" : "R4 latency",
              lat, exp_hit ? 2 : RD_LAT + 2);
        check(!rdy, "R4 ready low while busy", int'(rdy), 0);
        if (filled)
            check(last_rd_addr == a, "R4 fill address", int'(last_rd_addr), int'(a));
    endtask

    task automatic wr_chk(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        logic [DATA_W-1:0] rd, wdo;
        logic [ADDR_W-1:0] wa;
        int lat;
        bit filled, rdy, ws;
        access(1'b1, a, d, rd, lat, filled, rdy, ws, wa, wdo);
        check(ws && wa == a && wdo == d, "R8 write-through", int'(wa), int'(a));
        check(lat == 2, "R8 write latency", lat, 2);
        check(!filled, "R10 write issues no read", int'(filled), 0);
    endtask

    task automatic t_reset();
        check(cpu_req_ready == 1'b1, "R1 ready after reset", int'(cpu_req_ready), 1);
        check(!cpu_rsp_valid && !mem_rd_valid && !mem_wr_valid, "R1 idle outputs",
              int'({cpu_rsp_valid, mem_rd_valid, mem_wr_valid}), 0);
    endtask

    task automatic t_cold();
        rd_chk(mk(1, 5), 1'b0, "R1 cold miss");
        rd_chk(mk(1, 5), 1'b1, "R3 repeat hit");
        rd_chk(mk(1, 6), 1'b0, "R2 other index same tag");
        rd_chk(mk(1, 5), 1'b1, "R2 index kept apart");
    endtask

    task automatic t_ways();
        rd_chk(mk(2, 5), 1'b0, "R5 fill invalid way");
        rd_chk(mk(1, 5), 1'b1, "R5 first entry kept");
        rd_chk(mk(2, 5), 1'b1, "R5 second entry hits");
    endtask

    task automatic t_lru();
        // set 5 holds tags 1,2; tag 2 used last so tag 1 is the victim
        rd_chk(mk(3, 5), 1'b0, "R6 miss in full set");
        rd_chk(mk(2, 5), 1'b1, "R6 recent way survives");
        rd_chk(mk(1, 5), 1'b0, "R6 least recent evicted");
        // now tags 2(way?) and 1; hit on 1 then miss must evict 2
        rd_chk(mk(1, 5), 1'b1, "R7 hit before miss");
        rd_chk(mk(4, 5), 1'b0, "R7 miss after hit");
        rd_chk(mk(1, 5), 1'b1, "R7 hit way protected");
        rd_chk(mk(2, 5), 1'b0, "R7 other way replaced");
    endtask

    task automatic t_wr_hit();
        rd_chk(mk(4, 20), 1'b0, "R9 prime");
        wr_chk(mk(4, 20), 12'hABC);
        rd_chk(mk(4, 20), 1'b1, "R9 write hit updates data");
        rd_chk(mk(5, 20), 1'b0, "R7 second way");
        wr_chk(mk(4, 20), 12'h3C5);
        rd_chk(mk(6, 20), 1'b0, "R7 write hit refreshes recency");
        rd_chk(mk(4, 20), 1'b1, "R7 written way kept");
        rd_chk(mk(5, 20), 1'b0, "R7 untouched way evicted");
    endtask

    task automatic t_wr_miss();
        wr_chk(mk(7, 40), 12'h123);
        rd_chk(mk(7, 40), 1'b0, "R10 write miss not installed");
        rd_chk(mk(8, 41), 1'b0, "R10 prime a");
        rd_chk(mk(9, 41), 1'b0, "R10 prime b");
        wr_chk(mk(10, 41), 12'h777);
        rd_chk(mk(8, 41), 1'b1, "R10 entry a kept");
        rd_chk(mk(9, 41), 1'b1, "R10 entry b kept");
        rd_chk(mk(10, 41), 1'b0, "R10 written address still misses");
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cold();
        t_ways();
        t_lru();
        t_wr_hit();
        t_wr_miss();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 50000, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule